// File: doc/BRIEF.md
# Multi-Turn Incremental Position Tracker

This block turns a free-running 16-bit encoder count into a signed position that covers any number of whole revolutions, for encoders whose counts per revolution need not be a power of two. On each sample strobe it takes the signed change in the count since the previous sample and adds it to a running position. It then folds that position back by one revolution if it has left a programmable window. The window is set by an upper and a lower limit, which may be signed (centred on zero) or unsigned.

The position has no meaning until the first index pulse. That pulse clears the position and captures the count at that instant as the reference. Later index pulses are ignored until software pulses the re-arm input. Configuration is static while armed: `cfg_cpr`, `cfg_upper` and `cfg_lower` must satisfy `upper - lower = N*cpr - 1` for N tracked turns. The sample rate must keep each sample's change small enough that one fold step is always enough.

Top module: `mturn_pos_tracker`

## Requirements
- R1: In reset, and in the first cycle after it, `pos_out` is 0 and `armed_out`, `pos_valid` and `ovf_out` are all low.
- R2: While `armed_out` is low, a sample strobe is ignored: `pos_valid` stays low and `pos_out` keeps its value.
- R3: An index pulse while unarmed, with `rearm_in` low, sets `pos_out` to 0 and `armed_out` high on the next clock, and takes the current count as the reference count. A sample strobe in that same cycle is ignored.
- R4: An index pulse while armed changes neither `pos_out` nor the reference count.
- R5: A sample strobe while armed, with `rearm_in` low, adds the signed difference (count minus reference) to the position and makes the current count the new reference. The result appears on `pos_out` one clock later, together with a one-cycle high pulse on `pos_valid`.
- R6: The count difference is taken modulo 2^16 and read as a two's-complement value, so a count that wraps between FFFFh and 0000h gives the correct small delta.
- R7: After the update, a sum above `cfg_upper` has `cfg_cpr` subtracted from it, and a sum below `cfg_lower` has `cfg_cpr` added to it, in one step only.
- R8: The same logic serves a signed one-turn window (9, 4, -4), a two-turn window (9, 8, -9) and an unsigned window (9, 8, 0).
- R9: `ovf_out` is set on the clock that registers a sample whose unfolded sum leaves the signed 16-bit range, or whose folded result still lies outside the window. It stays set until reset or re-arm.
- R10: A `rearm_in` pulse clears `armed_out` and `ovf_out` on the next clock, and leaves `pos_out` as it was. An index or sample in that same cycle is ignored. The next index pulse then initialises the block again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_in | input | 16 | Free-running encoder count |
| index_in | input | 1 | Once-per-revolution index pulse |
| sample_in | input | 1 | Sample strobe |
| rearm_in | input | 1 | Clears the armed state so the next index initialises again |
| cfg_cpr | input | 16 | Counts per revolution (unsigned) |
| cfg_upper | input | 16 | Upper window limit (signed) |
| cfg_lower | input | 16 | Lower window limit (signed) |
| pos_out | output | 16 | Signed position |
| pos_valid | output | 1 | One-cycle pulse when `pos_out` holds a new sample result |
| armed_out | output | 1 | High once an index pulse has initialised the block |
| ovf_out | output | 1 | Sticky overflow flag |

## Verification
Every result is one register deep. The position, valid pulse and overflow flag from a sample strobe, the cleared position and the armed flag from an index pulse, and the cleared flags from a re-arm all appear after the first rising edge that sees the stimulus. The bench changes inputs on falling edges and holds each strobe for exactly one cycle. It reads the outputs on the next falling edge, half a cycle after the register updates. One further falling edge later it confirms that the valid pulse has dropped. Long runs of samples with varying deltas, including count wraps, are swept through three window configurations. Each result is compared against an integer model of the add, fold and overflow rules kept in the bench.

// File: rtl/mturn_pos_pkg.sv
`timescale 1ns/1ps
package mturn_pos_pkg;
  // which correction the fold stage applied
  typedef enum logic [1:0] {
    FOLD_NONE = 2'd0,
    FOLD_DOWN = 2'd1,
    FOLD_UP   = 2'd2
  } fold_e;
endpackage

// File: rtl/mturn_delta.sv
`timescale 1ns/1ps
// Modulo-2^W difference between the new count and the reference count.
module mturn_delta #(
  parameter int W = 16
) (
  input  logic [W-1:0]        count_now,
  input  logic [W-1:0]        count_ref,
  output logic signed [W-1:0] delta
);
  always_comb begin
    delta = $signed(count_now - count_ref);
  end
endmodule

// File: rtl/mturn_fold.sv
`timescale 1ns/1ps
// Adds the delta to the position and folds the sum once into the window.
module mturn_fold
  import mturn_pos_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] pos_cur,
  input  logic signed [W-1:0] delta,
  input  logic [W-1:0]        cpr,
  input  logic signed [W-1:0] upper,
  input  logic signed [W-1:0] lower,
  output logic signed [W-1:0] pos_next,
  output fold_e               action,
  output logic                ovf_evt
);
  localparam int SW = W + 2;
  localparam logic signed [SW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {3'b111, {(W-1){1'b0}}};

  logic signed [SW-1:0] sum_w, cpr_w, up_w, lo_w, fold_w;
  logic range_bad, step_bad;

  always_comb begin
    cpr_w = $signed({2'b00, cpr});
    up_w  = SW'(upper);
    lo_w  = SW'(lower);
    sum_w = SW'(pos_cur) + SW'(delta);
    if (sum_w > up_w) begin
      fold_w = sum_w - cpr_w;
      action = FOLD_DOWN;
    end else if (sum_w < lo_w) begin
      fold_w = sum_w + cpr_w;
      action = FOLD_UP;
    end else begin
      fold_w = sum_w;
      action = FOLD_NONE;
    end
    range_bad = (sum_w > MAXV) || (sum_w < MINV);
    step_bad  = (fold_w > up_w) || (fold_w < lo_w);
    ovf_evt   = range_bad || step_bad;
    pos_next  = fold_w[W-1:0];
  end
endmodule

// File: rtl/mturn_arm.sv
`timescale 1ns/1ps
// One-shot arming on the index pulse, cleared by re-arm.
module mturn_arm (
  input  logic clk,
  input  logic rst,
  input  logic index_in,
  input  logic rearm_in,
  output logic armed,
  output logic init_pulse
);
  always_comb begin
    init_pulse = index_in && !armed && !rearm_in;
  end

  always_ff @(posedge clk) begin
    if (rst || rearm_in) armed <= 1'b0;
    else if (init_pulse) armed <= 1'b1;
  end
endmodule

// File: rtl/mturn_pos_tracker.sv
`timescale 1ns/1ps
module mturn_pos_tracker
  import mturn_pos_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        count_in,
  input  logic                index_in,
  input  logic                sample_in,
  input  logic                rearm_in,
  input  logic [W-1:0]        cfg_cpr,
  input  logic signed [W-1:0] cfg_upper,
  input  logic signed [W-1:0] cfg_lower,
  output logic signed [W-1:0] pos_out,
  output logic                pos_valid,
  output logic                armed_out,
  output logic                ovf_out
);
  logic [W-1:0]        ref_q;
  logic signed [W-1:0] delta, pos_nx;
  logic                armed, init_p, ovf_evt, take;
  fold_e               act;

  mturn_arm u_arm (
    .clk(clk), .rst(rst), .index_in(index_in), .rearm_in(rearm_in),
    .armed(armed), .init_pulse(init_p)
  );

  mturn_delta #(.W(W)) u_delta (
    .count_now(count_in), .count_ref(ref_q), .delta(delta)
  );

  mturn_fold #(.W(W)) u_fold (
    .pos_cur(pos_out), .delta(delta), .cpr(cfg_cpr),
    .upper(cfg_upper), .lower(cfg_lower),
    .pos_next(pos_nx), .action(act), .ovf_evt(ovf_evt)
  );

  always_comb take = sample_in && armed && !rearm_in;
  assign armed_out = armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_out   <= '0;
      ref_q     <= '0;
      pos_valid <= 1'b0;
      ovf_out   <= 1'b0;
    end else begin
      pos_valid <= 1'b0;
      if (rearm_in) begin
        ovf_out <= 1'b0;
      end else if (init_p) begin
        pos_out <= '0;
        ref_q   <= count_in;
      end else if (take) begin
        pos_out   <= pos_nx;
        ref_q     <= count_in;
        pos_valid <= 1'b1;
        if (ovf_evt) ovf_out <= 1'b1;
      end
    end
  end

  // R2: unarmed with no index leaves the position alone and no valid
  a_r2_unarmed_idle: assert property (@(posedge clk) disable iff (rst)
    (!armed && !index_in) |=> (!pos_valid && $stable(pos_out)));

  // R3: the first index clears the position and arms
  a_r3_index_init: assert property (@(posedge clk) disable iff (rst)
    (index_in && !armed && !rearm_in) |=> (armed_out && pos_out == '0));

  // R4: armed stays set without a re-arm
  a_r4_armed_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !rearm_in) |=> armed_out);

  // R5: valid only follows an accepted sample
  a_r5_valid_source: assert property (@(posedge clk) disable iff (rst)
    pos_valid |-> $past(sample_in && armed && !rearm_in));

  // R7: a clean result lies inside the window
  a_r7_in_window: assert property (@(posedge clk) disable iff (rst)
    (pos_valid && !ovf_out) |-> (pos_out <= cfg_upper && pos_out >= cfg_lower));

  // R9: overflow is sticky until re-arm
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_out && !rearm_in) |=> ovf_out);

  // R10: armed drops only after a re-arm request
  a_r10_fall_by_rearm: assert property (@(posedge clk) disable iff (rst)
    $fell(armed) |-> $past(rearm_in));
endmodule

// File: tb/mturn_pos_tracker_tb_top.sv
`timescale 1ns/1ps
module mturn_pos_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] count_in = '0;
  logic index_in = 1'b0, sample_in = 1'b0, rearm_in = 1'b0;
  logic [15:0] cfg_cpr = 16'd9;
  logic signed [15:0] cfg_upper = 16'sd4, cfg_lower = -16'sd4;
  logic signed [15:0] pos_out;
  logic pos_valid, armed_out, ovf_out;

  int checks = 0, errors = 0;
  int pos_m = 0, old_m = 0, cpr_m = 9, hi_m = 4, lo_m = -4;
  bit ovf_m = 0;

  always #4 clk = ~clk;

  mturn_pos_tracker dut_i (
    .clk(clk), .rst(rst), .count_in(count_in), .index_in(index_in),
    .sample_in(sample_in), .rearm_in(rearm_in), .cfg_cpr(cfg_cpr),
    .cfg_upper(cfg_upper), .cfg_lower(cfg_lower), .pos_out(pos_out),
    .pos_valid(pos_valid), .armed_out(armed_out), .ovf_out(ovf_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int cpr, input int hi, input int lo);
    @(negedge clk);
    cpr_m = cpr; hi_m = hi; lo_m = lo;
    cfg_cpr = 16'(cpr); cfg_upper = 16'(hi); cfg_lower = 16'(lo);
  endtask

  task automatic pulse_index(input int c, input bit also_sample);
    @(negedge clk);
    count_in = 16'(c); index_in = 1'b1; sample_in = also_sample;
    @(negedge clk);
    index_in = 1'b0; sample_in = 1'b0;
  endtask

  task automatic pulse_rearm();
    @(negedge clk);
    rearm_in = 1'b1;
    @(negedge clk);
    rearm_in = 1'b0;
  endtask

  // accepted sample: update model, drive, compare
  task automatic armed_sample(input int c, input string req);
    int d, s, f;
    d = int'($signed(16'(c - old_m)));
    s = pos_m + d;
    if (s > 32767 || s < -32768) ovf_m = 1;
    if (s > hi_m) f = s - cpr_m;
    else if (s < lo_m) f = s + cpr_m;
    else f = s;
    if (f > hi_m || f < lo_m) ovf_m = 1;
    pos_m = int'($signed(16'(f)));
    old_m = c & 16'hFFFF;
    @(negedge clk);
    count_in = 16'(c); sample_in = 1'b1;
    @(negedge clk);
    sample_in = 1'b0;
    check(pos_valid === 1'b1, req, "valid pulse", int'(pos_valid), 1);
    check(pos_out === 16'(pos_m), req, "position", int'(pos_out), pos_m);
    check(ovf_out === ovf_m, "R9", "overflow flag", int'(ovf_out), int'(ovf_m));
  endtask

  task automatic sweep(input int start, input int n, input int span, input string req);
    pulse_index(start, 1'b0);
    pos_m = 0; old_m = start & 16'hFFFF; ovf_m = 0;
    check(armed_out === 1'b1 && pos_out === 16'sd0, "R3", "init", int'(pos_out), 0);
    for (int i = 0; i < n; i++) begin
      int d;
      d = ((i * 7 + i / 5) % (2 * span + 1)) - span;
      armed_sample(old_m + d, req);
      @(negedge clk);
      check(pos_valid === 1'b0, "R5", "pulse width", int'(pos_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(pos_out === 16'sd0 && armed_out === 1'b0 && pos_valid === 1'b0 &&
          ovf_out === 1'b0, "R1", "reset outputs", int'(pos_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(armed_out === 1'b0 && ovf_out === 1'b0, "R1", "after reset", int'(armed_out), 0);

    // R2: samples ignored while unarmed
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      count_in = 16'(100 + 37 * i); sample_in = 1'b1;
      @(negedge clk);
      sample_in = 1'b0;
      check(pos_valid === 1'b0, "R2", "no valid", int'(pos_valid), 0);
      check(pos_out === 16'sd0, "R2", "pos held", int'(pos_out), 0);
    end

    // R3: index with simultaneous sample, sample ignored
    pulse_index(500, 1'b1);
    check(pos_valid === 1'b0, "R3", "sample ignored at init", int'(pos_valid), 0);
    check(armed_out === 1'b1 && pos_out === 16'sd0, "R3", "armed", int'(armed_out), 1);
    pos_m = 0; old_m = 500; ovf_m = 0;
    armed_sample(503, "R5");

    // R4: later index ignored
    pulse_index(900, 1'b0);
    check(pos_out === 16'(pos_m), "R4", "pos after 2nd index", int'(pos_out), pos_m);
    armed_sample(501, "R4"); // delta from 503, not from 900

    // R10: rearm then reinit
    pulse_rearm();
    check(armed_out === 1'b0, "R10", "armed cleared", int'(armed_out), 0);
    check(pos_out === 16'(pos_m), "R10", "pos kept", int'(pos_out), pos_m);
    @(negedge clk);
    count_in = 16'd42; rearm_in = 1'b1; index_in = 1'b1;
    @(negedge clk);
    rearm_in = 1'b0; index_in = 1'b0;
    check(armed_out === 1'b0, "R10", "index blocked by rearm", int'(armed_out), 0);

    // R6, R7, R8: signed one turn, wrap through FFFFh
    sweep(16'hFFF8, 160, 4, "R6");
    pulse_rearm();
    // R8: two turns
    set_cfg(9, 8, -9);
    sweep(16'hFFFC, 160, 5, "R8");
    pulse_rearm();
    // R8: unsigned window
    set_cfg(9, 8, 0);
    sweep(3, 160, 5, "R7");
    pulse_rearm();

    // R9: one fold step not enough
    set_cfg(9, 4, -4);
    sweep(10, 0, 1, "R9");
    armed_sample(30, "R9");
    check(ovf_out === 1'b1, "R9", "step overflow", int'(ovf_out), 1);
    armed_sample(31, "R9");
    check(ovf_out === 1'b1, "R9", "sticky", int'(ovf_out), 1);
    pulse_rearm();
    check(ovf_out === 1'b0, "R10", "ovf cleared", int'(ovf_out), 0);

    // R9: range overflow with wide window
    set_cfg(60001, 30000, -30000);
    sweep(0, 0, 1, "R9");
    armed_sample(30000, "R9");
    check(ovf_out === 1'b0, "R9", "in range", int'(ovf_out), 0);
    armed_sample(60000, "R9");
    check(ovf_out === 1'b1, "R9", "range overflow", int'(ovf_out), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule